// File: doc/BRIEF.md
# Exception Entry State Sequencer

This block commits every architectural state change that goes with taking a trap. A trap here is a synchronous exception, an accepted interrupt or a debug breakpoint. The pipeline presents the trap on a one-cycle accept strobe, together with the following inputs:

- a 15-bit cause code, with the major code in bits [5:0] and the subcode in bits [14:6];
- the faulting PC and the faulting instruction word;
- a flag that says a TLB refill is in progress;
- the current mode bits;
- the vector spacing selector, the interrupt index picked by an external priority encoder, and the two entry base addresses.

On the next clock edge the block writes the mode, saved-mode, return-address, bad-address, bad-instruction, cause and debug registers at once. It also emits the redirect PC with a one-cycle redirect pulse.

Each trap takes one of three paths, and each path saves to its own registers:

- The normal path saves to the trap registers.
- The refill path saves to the refill registers and forces direct-address mode.
- The debug path saves to the debug registers and jumps to a fixed offset.

A debug-return strobe leaves debug state. A cause code outside the supported set is rejected with an error pulse, and no state changes.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, every saved register, cause field and debug flag reads 0. The mode reads PLV=0, IE=0, DA=1, PG=0, and the PC reads the RESET_PC parameter.
- R2: On every legal accept, the next cycle shows PLV=0, IE=0 and a one-cycle redirect pulse. Except on the refill path, DA and PG take the current DA and PG inputs.
- R3: On the normal path, the major code and subcode go to the cause fields, the current PLV and IE go to the saved-mode register, and the PC goes to the return-address register.
- R4: A normal-path non-interrupt trap redirects to entry base + major × spacing. The spacing is 4·2^VS, or 0 when VS=0.
- R5: An interrupt (major 0x00) that is not in debug state redirects to entry base + (64 + interrupt index) × spacing, on the normal path and on the refill path alike.
- R6: The bad-address register is loaded with the PC only for majors 0x0B through 0x12 (syscall, break, reserved instruction, privileged instruction, FP disabled, the two vector-disabled codes and FP exception).
- R7: The bad-instruction register is loaded with the instruction word on every legal non-debug trap except interrupts, fetch page-invalid (major 0x03) and fetch address error (major 0x08, subcode 0).
- R8: When the refill flag is set and the trap is not on the debug path:
  - the current PLV and IE go to the refill saved-mode register;
  - DA=1 and PG=0 are forced;
  - PC>>2 goes to the refill return field;
  - a non-interrupt trap redirects to the refill entry base;
  - the normal cause, return and saved-mode registers are left unchanged.
- R9: A debug breakpoint (major 0x3F) takes the debug path. It sets the debug-cause flag, writes debug code 0x0C, saves the PC to the debug return register, sets debug state and redirects to entry base + 0x480. The normal registers are left unchanged.
- R10: An interrupt accepted while in debug state takes the debug path. It sets the debug-interrupt flag and leaves the debug-cause flag and debug code unchanged.
- R11: Legal causes are:
  - subcode 0 with majors 0x00–0x07, 0x0A–0x12 and 0x3F;
  - major 0x08 with subcode 0 or 1.

  Any other cause on accept gives a one-cycle error pulse, no redirect, and no change to any register.
- R12: A debug-return strobe without accept clears debug state, the debug-cause flag and the debug-interrupt flag. With accept high it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | Trap accept strobe |
| cause_i | input | 15 | {subcode[8:0], major[5:0]} |
| epc_i | input | XLEN | Faulting PC |
| einsn_i | input | 32 | Faulting instruction word |
| refill_i | input | 1 | TLB refill in progress |
| cur_plv_i | input | 2 | Current privilege level |
| cur_ie_i | input | 1 | Current interrupt enable |
| cur_da_i | input | 1 | Current direct-address bit |
| cur_pg_i | input | 1 | Current paging bit |
| vs_i | input | 3 | Vector spacing selector |
| irq_idx_i | input | IRQ_W | Selected interrupt index |
| ebase_i | input | XLEN | Trap entry base |
| rfbase_i | input | XLEN | Refill entry base |
| dret_i | input | 1 | Debug return strobe |
| pc_o | output | XLEN | Redirect PC |
| redirect_o | output | 1 | Redirect pulse |
| err_o | output | 1 | Undefined cause pulse |
| plv_o | output | 2 | Mode PLV |
| ie_o | output | 1 | Mode IE |
| da_o | output | 1 | Mode DA |
| pg_o | output | 1 | Mode PG |
| pplv_o | output | 2 | Saved PLV |
| pie_o | output | 1 | Saved IE |
| era_o | output | XLEN | Return address |
| ecode_o | output | 6 | Major cause |
| esub_o | output | 9 | Subcode |
| badv_o | output | XLEN | Bad address |
| badi_o | output | 32 | Bad instruction |
| rf_pplv_o | output | 2 | Refill saved PLV |
| rf_pie_o | output | 1 | Refill saved IE |
| rf_era_o | output | XLEN-2 | Refill return (PC>>2) |
| dbg_state_o | output | 1 | Debug state |
| dbg_cause_o | output | 1 | Debug breakpoint flag |
| dbg_int_o | output | 1 | Debug interrupt flag |
| dbg_code_o | output | 6 | Debug code |
| dera_o | output | XLEN | Debug return address |

## Verification
The bench drives the following patterns:

- normal faults at several spacing settings, to separate the VS=0 zero-spacing case from the shifted offsets;
- the fetch, memory and syscall-class causes, to tell apart which ones load the bad-address register and which load the bad-instruction register;
- refill and non-refill versions of the same fault, to show which register set each path writes;
- a debug breakpoint, then an interrupt inside debug state, then a debug return, then an interrupt outside debug state, to separate the two debug flags and show that leaving debug state restores the normal interrupt path;
- undefined major codes and undefined subcodes, to confirm that all state is frozen.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int MAJ_W   = 6;
  localparam int SUB_W   = 9;
  localparam int CAUSE_W = MAJ_W + SUB_W;

  localparam logic [MAJ_W-1:0] MC_INT  = 6'h00;
  localparam logic [MAJ_W-1:0] MC_PIF  = 6'h03;
  localparam logic [MAJ_W-1:0] MC_PPI  = 6'h07;
  localparam logic [MAJ_W-1:0] MC_ADE  = 6'h08;
  localparam logic [MAJ_W-1:0] MC_BCE  = 6'h0A;
  localparam logic [MAJ_W-1:0] MC_SYS  = 6'h0B;
  localparam logic [MAJ_W-1:0] MC_FPE  = 6'h12;
  localparam logic [MAJ_W-1:0] MC_DBP  = 6'h3F;

  localparam logic [MAJ_W-1:0] DBG_BRK_CODE = 6'h0C;
  localparam int               IRQ_BASE     = 64;
  localparam int               DBG_OFFSET   = 'h480;

  typedef enum logic [1:0] {
    PATH_NORM   = 2'd0,
    PATH_REFILL = 2'd1,
    PATH_DEBUG  = 2'd2
  } path_e;

  typedef struct packed {
    logic legal;
    logic is_int;
    logic is_dbg_brk;
    logic set_badv;
    logic set_badi;
  } cause_cls_t;

  // Byte offset of vector slot idx: idx * 4 * 2^vs, or 0 when vs is 0.
  function automatic logic [63:0] vec_offset(input logic [2:0] vs,
                                             input logic [7:0] idx);
    logic [3:0] sh;
    sh = {1'b0, vs} + 4'd2;
    if (vs == 3'd0) return 64'd0;
    return 64'(idx) << sh;
  endfunction

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
(
  input  logic [MAJ_W-1:0] major_i,
  input  logic [SUB_W-1:0] sub_i,
  output cause_cls_t       cls_o
);

  logic known_major;
  logic sub_ok;
  logic fetch_fault;

  always_comb begin
    known_major = 1'b0;
    sub_ok      = (sub_i == '0);
    if (major_i <= MC_PPI)                          known_major = 1'b1;
    if (major_i >= MC_BCE && major_i <= MC_FPE)     known_major = 1'b1;
    if (major_i == MC_DBP)                          known_major = 1'b1;
    if (major_i == MC_ADE) begin
      known_major = 1'b1;
      sub_ok      = (sub_i <= 9'd1);
    end
  end

  assign fetch_fault = (major_i == MC_PIF) ||
                       ((major_i == MC_ADE) && (sub_i == '0));

  always_comb begin
    cls_o.legal      = known_major && sub_ok;
    cls_o.is_int     = (major_i == MC_INT);
    cls_o.is_dbg_brk = (major_i == MC_DBP);
    cls_o.set_badv   = cls_o.legal && (major_i >= MC_SYS) && (major_i <= MC_FPE);
    cls_o.set_badi   = cls_o.legal && !cls_o.is_int && !cls_o.is_dbg_brk && !fetch_fault;
  end

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IRQ_W = 4
) (
  input  path_e            path_i,
  input  logic             is_int_i,
  input  logic [MAJ_W-1:0] major_i,
  input  logic [IRQ_W-1:0] irq_idx_i,
  input  logic [2:0]       vs_i,
  input  logic [XLEN-1:0]  ebase_i,
  input  logic [XLEN-1:0]  rfbase_i,
  output logic [XLEN-1:0]  target_o
);

  logic [7:0]      irq_slot;
  logic [XLEN-1:0] int_off;
  logic [XLEN-1:0] exc_off;

  assign irq_slot = 8'(IRQ_BASE) + 8'(irq_idx_i);
  assign int_off  = XLEN'(vec_offset(vs_i, irq_slot));
  assign exc_off  = XLEN'(vec_offset(vs_i, 8'(major_i)));

  always_comb begin
    unique case (path_i)
      PATH_DEBUG:  target_o = ebase_i + XLEN'(DBG_OFFSET);
      PATH_REFILL: target_o = is_int_i ? ebase_i + int_off : rfbase_i;
      default:     target_o = is_int_i ? ebase_i + int_off : ebase_i + exc_off;
    endcase
  end

endmodule

// File: rtl/exc_debug_regs.sv
module exc_debug_regs
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_dbg_i,
  input  logic             from_int_i,
  input  logic             dret_i,
  input  logic [XLEN-1:0]  pc_i,
  output logic             state_o,
  output logic             cause_o,
  output logic             int_o,
  output logic [MAJ_W-1:0] code_o,
  output logic [XLEN-1:0]  dera_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= 1'b0;
      cause_o <= 1'b0;
      int_o   <= 1'b0;
      code_o  <= '0;
      dera_o  <= '0;
    end else if (take_dbg_i) begin
      state_o <= 1'b1;
      dera_o  <= pc_i;
      if (from_int_i) begin
        int_o <= 1'b1;
      end else begin
        cause_o <= 1'b1;
        code_o  <= DBG_BRK_CODE;
      end
    end else if (dret_i) begin
      state_o <= 1'b0;
      cause_o <= 1'b0;
      int_o   <= 1'b0;
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          IRQ_W    = 4,
  parameter logic [63:0] RESET_PC = 64'h1C00_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic [14:0]        cause_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [31:0]        einsn_i,
  input  logic               refill_i,
  input  logic [1:0]         cur_plv_i,
  input  logic               cur_ie_i,
  input  logic               cur_da_i,
  input  logic               cur_pg_i,
  input  logic [2:0]         vs_i,
  input  logic [IRQ_W-1:0]   irq_idx_i,
  input  logic [XLEN-1:0]    ebase_i,
  input  logic [XLEN-1:0]    rfbase_i,
  input  logic               dret_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               redirect_o,
  output logic               err_o,
  output logic [1:0]         plv_o,
  output logic               ie_o,
  output logic               da_o,
  output logic               pg_o,
  output logic [1:0]         pplv_o,
  output logic               pie_o,
  output logic [XLEN-1:0]    era_o,
  output logic [5:0]         ecode_o,
  output logic [8:0]         esub_o,
  output logic [XLEN-1:0]    badv_o,
  output logic [31:0]        badi_o,
  output logic [1:0]         rf_pplv_o,
  output logic               rf_pie_o,
  output logic [XLEN-3:0]    rf_era_o,
  output logic               dbg_state_o,
  output logic               dbg_cause_o,
  output logic               dbg_int_o,
  output logic [5:0]         dbg_code_o,
  output logic [XLEN-1:0]    dera_o
);

  logic [MAJ_W-1:0] major;
  logic [SUB_W-1:0] sub;
  cause_cls_t       cls;
  path_e            path;
  logic             take_ok;
  logic             take_bad;
  logic             take_int;
  logic             path_dbg;
  logic             path_rfl;
  logic [XLEN-1:0]  target;

  assign major = cause_i[MAJ_W-1:0];
  assign sub   = cause_i[CAUSE_W-1:MAJ_W];

  exc_cause_decode u_dec (
    .major_i (major),
    .sub_i   (sub),
    .cls_o   (cls)
  );

  assign take_ok  = accept_i && cls.legal;
  assign take_bad = accept_i && !cls.legal;
  assign take_int = cls.is_int;
  assign path_dbg = cls.is_dbg_brk || (cls.is_int && dbg_state_o);
  assign path_rfl = !path_dbg && refill_i;

  always_comb begin
    if (path_dbg)      path = PATH_DEBUG;
    else if (path_rfl) path = PATH_REFILL;
    else               path = PATH_NORM;
  end

  exc_target_calc #(.XLEN(XLEN), .IRQ_W(IRQ_W)) u_tgt (
    .path_i    (path),
    .is_int_i  (cls.is_int),
    .major_i   (major),
    .irq_idx_i (irq_idx_i),
    .vs_i      (vs_i),
    .ebase_i   (ebase_i),
    .rfbase_i  (rfbase_i),
    .target_o  (target)
  );

  exc_debug_regs #(.XLEN(XLEN)) u_dbg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_dbg_i (take_ok && path_dbg),
    .from_int_i (cls.is_int),
    .dret_i     (dret_i && !accept_i),
    .pc_i       (epc_i),
    .state_o    (dbg_state_o),
    .cause_o    (dbg_cause_o),
    .int_o      (dbg_int_o),
    .code_o     (dbg_code_o),
    .dera_o     (dera_o)
  );

  // Strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      redirect_o <= take_ok;
      err_o      <= take_bad;
    end
  end

  // Mode register and redirect PC
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o  <= XLEN'(RESET_PC);
      plv_o <= 2'd0;
      ie_o  <= 1'b0;
      da_o  <= 1'b1;
      pg_o  <= 1'b0;
    end else if (take_ok) begin
      pc_o  <= target;
      plv_o <= 2'd0;
      ie_o  <= 1'b0;
      da_o  <= path_rfl ? 1'b1 : cur_da_i;
      pg_o  <= path_rfl ? 1'b0 : cur_pg_i;
    end
  end

  // Normal-path save registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pplv_o  <= 2'd0;
      pie_o   <= 1'b0;
      era_o   <= '0;
      ecode_o <= '0;
      esub_o  <= '0;
    end else if (take_ok && (path == PATH_NORM)) begin
      pplv_o  <= cur_plv_i;
      pie_o   <= cur_ie_i;
      era_o   <= epc_i;
      ecode_o <= major;
      esub_o  <= sub;
    end
  end

  // Refill-path save registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_pplv_o <= 2'd0;
      rf_pie_o  <= 1'b0;
      rf_era_o  <= '0;
    end else if (take_ok && path_rfl) begin
      rf_pplv_o <= cur_plv_i;
      rf_pie_o  <= cur_ie_i;
      rf_era_o  <= epc_i[XLEN-1:2];
    end
  end

  // Fault capture registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      badv_o <= '0;
      badi_o <= '0;
    end else if (take_ok) begin
      if (cls.set_badv) badv_o <= epc_i;
      if (cls.set_badi) badi_o <= einsn_i;
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_i,
  input logic            dret_i,
  input logic [XLEN-1:0] epc_i,
  input logic            take_ok,
  input logic            take_bad,
  input logic            take_int,
  input logic            path_dbg,
  input logic            path_rfl,
  input logic [XLEN-1:0] pc_o,
  input logic            redirect_o,
  input logic            err_o,
  input logic [1:0]      plv_o,
  input logic            ie_o,
  input logic            da_o,
  input logic            pg_o,
  input logic [XLEN-1:0] era_o,
  input logic            dbg_state_o,
  input logic            dbg_int_o,
  input logic [5:0]      dbg_code_o,
  input logic [XLEN-1:0] dera_o
);

  // R2
  entry_mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (plv_o == 2'd0 && !ie_o && redirect_o && !err_o));

  // R11
  undef_cause_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |=> (err_o && !redirect_o && $stable(pc_o) && $stable(era_o) && $stable(plv_o)));

  // R8
  refill_forces_da_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && path_rfl) |=> (da_o && !pg_o));

  // R9
  debug_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && path_dbg) |=> (dbg_state_o && dera_o == $past(epc_i)));

  // R10
  debug_int_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && path_dbg && take_int) |=> (dbg_int_o && $stable(dbg_code_o)));

  // R12
  debug_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dret_i && !accept_i) |=> !dbg_state_o);

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept_i    (accept_i),
  .dret_i      (dret_i),
  .epc_i       (epc_i),
  .take_ok     (take_ok),
  .take_bad    (take_bad),
  .take_int    (take_int),
  .path_dbg    (path_dbg),
  .path_rfl    (path_rfl),
  .pc_o        (pc_o),
  .redirect_o  (redirect_o),
  .err_o       (err_o),
  .plv_o       (plv_o),
  .ie_o        (ie_o),
  .da_o        (da_o),
  .pg_o        (pg_o),
  .era_o       (era_o),
  .dbg_state_o (dbg_state_o),
  .dbg_int_o   (dbg_int_o),
  .dbg_code_o  (dbg_code_o),
  .dera_o      (dera_o)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic [14:0] cause_i = '0;
  logic [63:0] epc_i = '0;
  logic [31:0] einsn_i = '0;
  logic        refill_i = 1'b0;
  logic [1:0]  cur_plv_i = '0;
  logic        cur_ie_i = 1'b0;
  logic        cur_da_i = 1'b0;
  logic        cur_pg_i = 1'b1;
  logic [2:0]  vs_i = '0;
  logic [3:0]  irq_idx_i = '0;
  logic [63:0] ebase_i = 64'h9000_0000_0001_0000;
  logic [63:0] rfbase_i = 64'h9000_0000_0002_0000;
  logic        dret_i = 1'b0;

  logic [63:0] pc_o, era_o, badv_o, dera_o;
  logic [61:0] rf_era_o;
  logic [31:0] badi_o;
  logic [1:0]  plv_o, pplv_o, rf_pplv_o;
  logic        redirect_o, err_o, ie_o, da_o, pg_o, pie_o, rf_pie_o;
  logic        dbg_state_o, dbg_cause_o, dbg_int_o;
  logic [5:0]  ecode_o, dbg_code_o;
  logic [8:0]  esub_o;

  exc_entry_seq i_exc_entry_seq (.*);

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [63:0] e_pc, e_era, e_badv, e_dera, e_rera;
  logic [31:0] e_badi;
  logic [1:0]  e_plv, e_pplv, e_rpplv;
  logic        e_ie, e_da, e_pg, e_pie, e_rpie, e_dst, e_dcl, e_dei, e_red, e_err;
  logic [5:0]  e_ecode, e_dcode;
  logic [8:0]  e_esub;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input logic [5:0] mj, input logic [8:0] sb);
    if (mj == 6'h08) return sb < 9'd2;
    if (sb != 0) return 0;
    return (mj <= 6'h07) || (mj >= 6'h0A && mj <= 6'h12) || (mj == 6'h3F);
  endfunction

  task automatic compare_all(input string tag);
    chk(tag,  "pc",       pc_o, e_pc);
    chk(tag,  "redirect", 64'(redirect_o), 64'(e_red));
    chk("R11","err",      64'(err_o), 64'(e_err));
    chk("R2", "plv/ie",   {62'd0, plv_o} | 64'(ie_o) << 2, {62'd0, e_plv} | 64'(e_ie) << 2);
    chk("R2", "da/pg",    {62'd0, da_o, pg_o}, {62'd0, e_da, e_pg});
    chk("R3", "ecode",    64'(ecode_o), 64'(e_ecode));
    chk("R3", "esub",     64'(esub_o), 64'(e_esub));
    chk("R3", "saved",    {61'd0, pplv_o, pie_o}, {61'd0, e_pplv, e_pie});
    chk("R3", "era",      era_o, e_era);
    chk("R6", "badv",     badv_o, e_badv);
    chk("R7", "badi",     64'(badi_o), 64'(e_badi));
    chk("R8", "rf saved", {61'd0, rf_pplv_o, rf_pie_o}, {61'd0, e_rpplv, e_rpie});
    chk("R8", "rf era",   64'(rf_era_o), e_rera);
    chk("R9", "dbg flags",{61'd0, dbg_state_o, dbg_cause_o, dbg_int_o}, {61'd0, e_dst, e_dcl, e_dei});
    chk("R9", "dbg code", 64'(dbg_code_o), 64'(e_dcode));
    chk("R9", "dera",     dera_o, e_dera);
  endtask

  task automatic step(input bit acc, input logic [5:0] mj, input logic [8:0] sb,
                      input bit rf, input bit dr, input string tag);
    bit intr, dbgp;
    longint unsigned spacing;
    accept_i = acc; cause_i = {sb, mj}; refill_i = rf; dret_i = dr;
    e_red = 0; e_err = 0;
    if (acc) begin
      if (!legal(mj, sb)) e_err = 1;
      else begin
        intr = (mj == 6'h00);
        dbgp = (mj == 6'h3F) || (intr && e_dst);
        e_red = 1; e_plv = 0; e_ie = 0;
        if (mj inside {[6'h0B:6'h12]}) e_badv = epc_i;
        if (!intr && mj != 6'h3F && mj != 6'h03 && !(mj == 6'h08 && sb == 0)) e_badi = einsn_i;
        spacing = (vs_i == 0) ? 0 : 4 * (longint'(1) << vs_i);
        if (dbgp) begin
          e_dera = epc_i; e_dst = 1;
          if (intr) e_dei = 1; else begin e_dcl = 1; e_dcode = 6'h0C; end
          e_pc = ebase_i + 64'h480; e_da = cur_da_i; e_pg = cur_pg_i;
        end else begin
          if (rf) begin
            e_rpplv = cur_plv_i; e_rpie = cur_ie_i; e_da = 1; e_pg = 0; e_rera = epc_i >> 2;
          end else begin
            e_ecode = mj; e_esub = sb; e_pplv = cur_plv_i; e_pie = cur_ie_i;
            e_era = epc_i; e_da = cur_da_i; e_pg = cur_pg_i;
          end
          if (intr)    e_pc = ebase_i + (64 + irq_idx_i) * spacing;
          else if (rf) e_pc = rfbase_i;
          else         e_pc = ebase_i + mj * spacing;
        end
      end
    end else if (dr) begin
      e_dst = 0; e_dcl = 0; e_dei = 0;
    end
    @(posedge clk);
    @(negedge clk);
    accept_i = 0; dret_i = 0;
    compare_all(tag);
  endtask

  initial begin
    e_pc = 64'h1C00_0000; e_era = 0; e_badv = 0; e_dera = 0; e_rera = 0; e_badi = 0;
    e_plv = 0; e_pplv = 0; e_rpplv = 0; e_ie = 0; e_da = 1; e_pg = 0; e_pie = 0; e_rpie = 0;
    e_dst = 0; e_dcl = 0; e_dei = 0; e_red = 0; e_err = 0; e_ecode = 0; e_dcode = 0; e_esub = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R4 R6 R7: syscall, VS=0 gives zero spacing
    cur_plv_i = 2'd3; cur_ie_i = 1; epc_i = 64'h1200_0040; einsn_i = 32'h002B_0000; vs_i = 0;
    step(1, 6'h0B, 0, 0, 0, "R4");
    // R4: load page-invalid, VS=3 spacing 32, no badv
    cur_plv_i = 2'd1; epc_i = 64'h1200_0080; einsn_i = 32'h2880_0001; vs_i = 3;
    step(1, 6'h01, 0, 0, 0, "R4");
    // idle cycle: nothing moves
    step(0, 6'h01, 0, 0, 0, "R2");
    // R7: fetch page-invalid leaves badi
    epc_i = 64'h1200_00C0; einsn_i = 32'hDEAD_BEEF;
    step(1, 6'h03, 0, 0, 0, "R7");
    // R7: fetch address error (sub 0) vs memory address error (sub 1)
    epc_i = 64'h1200_0100; einsn_i = 32'h1111_2222;
    step(1, 6'h08, 0, 0, 0, "R7");
    einsn_i = 32'h3333_4444;
    step(1, 6'h08, 1, 0, 0, "R7");
    // R6: bound check does not load badv; FP exception does, at VS=7
    epc_i = 64'h1200_0140; vs_i = 7;
    step(1, 6'h0A, 0, 0, 0, "R6");
    epc_i = 64'h1200_0180;
    step(1, 6'h12, 0, 0, 0, "R6");
    // R5: interrupt index 5 at VS=2
    cur_ie_i = 1; cur_plv_i = 2'd2; vs_i = 2; irq_idx_i = 4'd5; epc_i = 64'h1200_01C0;
    step(1, 6'h00, 0, 0, 0, "R5");
    // R8: refill path for a load fault
    cur_plv_i = 2'd3; cur_ie_i = 1; cur_da_i = 0; cur_pg_i = 1; epc_i = 64'h1200_020C;
    step(1, 6'h01, 0, 1, 0, "R8");
    // R5 R8: interrupt during refill uses vector
    irq_idx_i = 4'd12; epc_i = 64'h1200_0300;
    step(1, 6'h00, 0, 1, 0, "R5");
    // R11: undefined major and undefined subcode
    epc_i = 64'h7777_0000;
    step(1, 6'h20, 0, 0, 0, "R11");
    step(1, 6'h0B, 9'd3, 0, 0, "R11");
    step(1, 6'h08, 9'd2, 0, 0, "R11");
    // R9: debug breakpoint
    epc_i = 64'h1200_0400; cur_plv_i = 2'd3; cur_ie_i = 1;
    step(1, 6'h3F, 0, 1, 0, "R9");
    // R10: interrupt in debug state
    epc_i = 64'h1200_0440; irq_idx_i = 4'd3;
    step(1, 6'h00, 0, 0, 0, "R10");
    // R12: dret ignored while accept high
    epc_i = 64'h1200_0480;
    step(1, 6'h0B, 0, 0, 1, "R12");
    // R12: dret alone clears
    step(0, 6'h00, 0, 0, 1, "R12");
    // R5: interrupt after debug return goes the normal way
    epc_i = 64'h1200_04C0; vs_i = 1;
    step(1, 6'h00, 0, 0, 0, "R5");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule